// File: doc/BRIEF.md
# DDS Parallel-Load Control Front End

This block is the control front end of a direct digital synthesizer. A host presents one byte at a time on an 8-bit bus and pulses a load strobe. Each load strobe edge stores the byte into a five-byte staging register at the position named by an auto-incrementing slot pointer. A separate apply strobe then copies the whole staging register into the active tuning word, the active phase offset and the clock-gating control in one step. Both strobes are asynchronous to the reference clock. Each one passes through a two-flop synchronizer and a rising-edge detector before it takes effect.

A master reset clears the active state and the slot pointer. It leaves the staging register as it was. A reset counts only when it is held for at least five reference-clock cycles. After a qualified reset is released, the block refuses strobes for two cycles. A separate flag reports when the synthesized output would reflect the cleared state, thirteen cycles after release. The phase accumulator, sine table and converter sit downstream and are outside this block.

Top module: `dds_load_ctrl`

## Requirements
- R1: Each accepted load-strobe rising edge writes `byte_i` into staging slot S0..S4 at the pointer, then advances the pointer. Once the pointer reaches S4 it stays there, and further loads overwrite S4.
- R2: An accepted apply-strobe rising edge updates the active state from the staging register and returns the pointer to S0. The tuning word becomes {S1,S2,S3,S4}, with S1 as the most significant byte. The phase word becomes S0[7:3].
- R3: S0[2] is the power-down bit. Applying an S0 whose low three bits are 100 drives `core_clk_en_o` low. Applying an S0 whose low three bits are 000 drives it high again.
- R4: A qualified reset, meaning `rst` held high for 5 or more consecutive clock edges, has the following effects:
  - the tuning word and phase word go to zero;
  - `core_clk_en_o` goes high;
  - the pointer returns to S0.
- R5: A reset held for fewer than 5 edges has no effect on the active outputs or on the pointer.
- R6: A qualified reset leaves the staging register contents unchanged. An apply with no new loads after the reset restores the earlier values.
- R7: `accept_rdy_o` is low during a qualified reset and for the first edge after release. It is high from the second edge after release. Strobe edges seen while it is low, or while `rst` is high, are ignored.
- R8: `out_valid_o` goes low on a qualified reset and rises at the 13th clock edge after release.
- R9: A strobe held high for many cycles acts exactly once.
- R10: Loads alone never change the active outputs. Only an apply or a qualified reset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Master reset, synchronous, active high, qualified by hold time |
| load_stb_i | input | 1 | Asynchronous byte-load strobe, acts on its rising edge |
| apply_stb_i | input | 1 | Asynchronous apply strobe, acts on its rising edge |
| byte_i | input | 8 | Byte to be stored by the next load |
| tune_word_o | output | 32 | Active frequency tuning word |
| phase_word_o | output | 5 | Active phase offset word |
| core_clk_en_o | output | 1 | Internal clock enable, low while powered down |
| accept_rdy_o | output | 1 | High once reset recovery has finished |
| out_valid_o | output | 1 | High once the reset latency has elapsed |

## Verification
A wrong pointer cannot be seen directly. It shows up only at the next apply, as bytes shifted or duplicated inside the tuning word. The bench therefore completes every load sequence with an apply and compares all 32 bits, six cycles after the strobe edge. A wrong reset qualifier or a wrong recovery counter shows up within a single cycle as a misplaced edge on `accept_rdy_o` or `out_valid_o`, so those edges are sampled at exact cycle counts after release. Loss of the staging data across reset appears only at the first apply after the reset, which the bench issues without reloading.

// File: rtl/dds_ctrl_pkg.sv
package dds_ctrl_pkg;
  localparam int DEF_BYTE_W   = 8;
  localparam int DEF_SLOTS    = 5;
  localparam int DEF_PHASE_W  = 5;
  localparam int DEF_RST_MIN  = 5;
  localparam int DEF_REC_CYC  = 2;
  localparam int DEF_LAT_CYC  = 13;
  localparam int DEF_SYNC_STG = 2;
  localparam int PD_BIT       = 2;

  // index of each strobe in the synchronizer array
  localparam int STB_LOAD  = 0;
  localparam int STB_APPLY = 1;
  localparam int NUM_STB   = 2;
endpackage

// File: rtl/dds_strobe_sync.sv
module dds_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q = '0;
  logic              last_q = 1'b0;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], async_i};
    last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dds_reset_qual.sv
module dds_reset_qual #(
  parameter int RST_MIN = 5,
  parameter int REC_CYC = 2,
  parameter int LAT_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  output logic clr_o,
  output logic ready_o,
  output logic valid_o
);
  localparam int HW = $clog2(RST_MIN + 1);
  localparam int RW = $clog2(REC_CYC + 1);
  localparam int LW = $clog2(LAT_CYC + 1);

  logic [HW-1:0] hold_q  = '0;
  logic [RW-1:0] rec_q   = '0;
  logic [LW-1:0] lat_q   = '0;
  logic          ready_q = 1'b0;
  logic          valid_q = 1'b0;

  // reset is honoured only from the RST_MIN-th consecutive high edge on
  assign clr_o = rst && (hold_q >= HW'(RST_MIN - 1));

  always_ff @(posedge clk) begin
    if (!rst)
      hold_q <= '0;
    else if (hold_q != HW'(RST_MIN))
      hold_q <= hold_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr_o) begin
      rec_q   <= '0;
      lat_q   <= '0;
      ready_q <= 1'b0;
      valid_q <= 1'b0;
    end else if (!rst) begin
      if (rec_q != RW'(REC_CYC)) rec_q <= rec_q + 1'b1;
      if (lat_q != LW'(LAT_CYC)) lat_q <= lat_q + 1'b1;
      ready_q <= (rec_q >= RW'(REC_CYC - 1));
      valid_q <= (lat_q >= LW'(LAT_CYC - 1));
    end
  end

  assign ready_o = ready_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dds_word_regs.sv
module dds_word_regs #(
  parameter int BYTE_W  = 8,
  parameter int SLOTS   = 5,
  parameter int PHASE_W = 5,
  parameter int PTR_W   = $clog2(SLOTS),
  parameter int TUNE_W  = (SLOTS - 1) * BYTE_W
) (
  input  logic              clk,
  input  logic              clr_i,
  input  logic              load_go_i,
  input  logic              apply_go_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [TUNE_W-1:0] tune_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic              clk_en_o,
  output logic [PTR_W-1:0]  ptr_o
);
  import dds_ctrl_pkg::*;

  localparam logic [PTR_W-1:0] LAST = PTR_W'(SLOTS - 1);

  logic [BYTE_W-1:0]  stage_mem [SLOTS];
  logic [PTR_W-1:0]   ptr_q   = '0;
  logic [TUNE_W-1:0]  tune_q  = '0;
  logic [PHASE_W-1:0] phase_q = '0;
  logic               clk_en_q = 1'b1;
  logic [TUNE_W-1:0]  tune_next;

  // staging memory: single write port, never reset
  always_ff @(posedge clk) begin
    if (load_go_i) stage_mem[ptr_q] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (clr_i || apply_go_i)
      ptr_q <= '0;
    else if (load_go_i && ptr_q != LAST)
      ptr_q <= ptr_q + 1'b1;
  end

  // slot 1 lands in the most significant byte
  always_comb begin
    tune_next = '0;
    for (int i = 1; i < SLOTS; i++)
      tune_next[(SLOTS - 1 - i) * BYTE_W +: BYTE_W] = stage_mem[i];
  end

  always_ff @(posedge clk) begin
    if (clr_i) begin
      tune_q   <= '0;
      phase_q  <= '0;
      clk_en_q <= 1'b1;
    end else if (apply_go_i) begin
      tune_q   <= tune_next;
      phase_q  <= stage_mem[0][BYTE_W-1 -: PHASE_W];
      clk_en_q <= ~stage_mem[0][PD_BIT];
    end
  end

  assign tune_o   = tune_q;
  assign phase_o  = phase_q;
  assign clk_en_o = clk_en_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/dds_load_ctrl.sv
module dds_load_ctrl
  import dds_ctrl_pkg::*;
#(
  parameter int BYTE_W   = DEF_BYTE_W,
  parameter int SLOTS    = DEF_SLOTS,
  parameter int PHASE_W  = DEF_PHASE_W,
  parameter int RST_MIN  = DEF_RST_MIN,
  parameter int REC_CYC  = DEF_REC_CYC,
  parameter int LAT_CYC  = DEF_LAT_CYC,
  parameter int SYNC_STG = DEF_SYNC_STG,
  localparam int TUNE_W  = (SLOTS - 1) * BYTE_W,
  localparam int PTR_W   = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_stb_i,
  input  logic               apply_stb_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic [TUNE_W-1:0]  tune_word_o,
  output logic [PHASE_W-1:0] phase_word_o,
  output logic               core_clk_en_o,
  output logic               accept_rdy_o,
  output logic               out_valid_o
);
  logic [NUM_STB-1:0] stb_raw;
  logic [NUM_STB-1:0] stb_rise;
  logic               clr;
  logic               accept;
  logic               load_go;
  logic               apply_go;
  logic [PTR_W-1:0]   slot_ptr;

  assign stb_raw[STB_LOAD]  = load_stb_i;
  assign stb_raw[STB_APPLY] = apply_stb_i;

  for (genvar g = 0; g < NUM_STB; g++) begin : g_sync
    dds_strobe_sync #(.STAGES(SYNC_STG)) i_sync (
      .clk    (clk),
      .async_i(stb_raw[g]),
      .rise_o (stb_rise[g])
    );
  end

  dds_reset_qual #(
    .RST_MIN(RST_MIN),
    .REC_CYC(REC_CYC),
    .LAT_CYC(LAT_CYC)
  ) i_rstq (
    .clk    (clk),
    .rst    (rst),
    .clr_o  (clr),
    .ready_o(accept_rdy_o),
    .valid_o(out_valid_o)
  );

  // apply wins over a load seen in the same cycle
  assign accept   = accept_rdy_o & ~rst;
  assign apply_go = accept & stb_rise[STB_APPLY];
  assign load_go  = accept & stb_rise[STB_LOAD] & ~stb_rise[STB_APPLY];

  dds_word_regs #(
    .BYTE_W (BYTE_W),
    .SLOTS  (SLOTS),
    .PHASE_W(PHASE_W)
  ) i_regs (
    .clk       (clk),
    .clr_i     (clr),
    .load_go_i (load_go),
    .apply_go_i(apply_go),
    .byte_i    (byte_i),
    .tune_o    (tune_word_o),
    .phase_o   (phase_word_o),
    .clk_en_o  (core_clk_en_o),
    .ptr_o     (slot_ptr)
  );
endmodule

// File: rtl/dds_load_ctrl_chk.sv
module dds_load_ctrl_chk #(
  parameter int TUNE_W = 32,
  parameter int PTR_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              accept_rdy_o,
  input logic              out_valid_o,
  input logic [TUNE_W-1:0] tune_word_o,
  input logic [PTR_W-1:0]  slot_ptr,
  input logic              apply_go
);
  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    accept_rdy_o |=> accept_rdy_o);

  // R8
  valid_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> accept_rdy_o);

  // R10
  tune_only_on_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(tune_word_o)) |-> $past(apply_go));

  // R7
  blocked_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(accept_rdy_o)) |-> $stable(slot_ptr));

  // R2
  ptr_home_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(apply_go)) |-> (slot_ptr == '0));
endmodule

bind dds_load_ctrl dds_load_ctrl_chk #(
  .TUNE_W(TUNE_W),
  .PTR_W (PTR_W)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .accept_rdy_o(accept_rdy_o),
  .out_valid_o (out_valid_o),
  .tune_word_o (tune_word_o),
  .slot_ptr    (slot_ptr),
  .apply_go    (apply_go)
);

// File: tb/test_dds_load_ctrl.sv
`timescale 1ns/1ps
module test_dds_load_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_stb = 1'b0;
  logic        apply_stb = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [31:0] tune;
  logic [4:0]  phase;
  logic        clk_en, rdy, vld;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dds_load_ctrl i_dds_load_ctrl (
    .clk(clk), .rst(rst), .load_stb_i(load_stb), .apply_stb_i(apply_stb),
    .byte_i(byte_in), .tune_word_o(tune), .phase_word_o(phase),
    .core_clk_en_o(clk_en), .accept_rdy_o(rdy), .out_valid_o(vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_byte(input logic [7:0] b);
    @(negedge clk); byte_in = b; load_stb = 1'b1;
    repeat (6) @(negedge clk);
    load_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic apply();
    @(negedge clk); apply_stb = 1'b1;
    repeat (6) @(negedge clk);
    apply_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic load_frame(input logic [7:0] w0, input logic [31:0] tw);
    load_byte(w0);
    for (int i = 3; i >= 0; i--) load_byte(tw[i*8 +: 8]);
  endtask

  // hold rst for n edges, release, then wait for recovery
  task automatic master_reset(input int n);
    @(negedge clk); rst = 1'b1;
    repeat (n) @(negedge clk);
    rst = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic t_reset_timing();
    @(negedge clk); rst = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 ready low in reset", rdy, 0);
    chk("R8 valid low in reset", vld, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 ready after 1 edge", rdy, 0);
    @(negedge clk);
    chk("R7 ready after 2 edges", rdy, 1);
    repeat (10) @(negedge clk);
    chk("R8 valid after 12 edges", vld, 0);
    @(negedge clk);
    chk("R8 valid after 13 edges", vld, 1);
    chk("R4 tune zero", tune, 0);
    chk("R4 phase zero", phase, 0);
    chk("R4 clk_en high", clk_en, 1);
  endtask

  task automatic t_frame();
    load_frame(8'b10101_000, 32'h12345678);
    chk("R10 tune unchanged before apply", tune, 0);
    apply();
    chk("R2 tune word", tune, 32'h12345678);
    chk("R2 phase word", phase, 5'h15);
    chk("R3 clk_en with 000", clk_en, 1);
    load_frame(8'b00011_000, 32'hCAFE0001);
    chk("R10 loads keep active word", tune, 32'h12345678);
    apply();
    chk("R2 second frame tune", tune, 32'hCAFE0001);
    chk("R2 second frame phase", phase, 5'h03);
  endtask

  task automatic t_power();
    load_frame(8'b00001_100, 32'h0A0B0C0D);
    apply();
    chk("R3 power-down 100", clk_en, 0);
    chk("R2 tune during power-down", tune, 32'h0A0B0C0D);
    load_frame(8'b00001_000, 32'h0A0B0C0D);
    apply();
    chk("R3 power-up 000", clk_en, 1);
  endtask

  task automatic t_saturate();
    load_byte(8'h00);
    load_byte(8'h11); load_byte(8'h22); load_byte(8'h33);
    load_byte(8'h44); load_byte(8'h55); load_byte(8'h66);
    apply();
    chk("R1 pointer holds at S4", tune, 32'h11223366);
  endtask

  task automatic t_short_reset();
    load_byte(8'b11111_000);
    load_byte(8'h9A);
    master_reset(3);
    chk("R5 short reset keeps tune", tune, 32'h11223366);
    chk("R5 short reset keeps ready", rdy, 1);
    load_byte(8'hBC); load_byte(8'hDE); load_byte(8'hF0);
    apply();
    chk("R5 pointer kept through short reset", tune, 32'h9ABCDEF0);
    chk("R5 phase after short reset", phase, 5'h1F);
  endtask

  task automatic t_retain_and_block();
    load_frame(8'b00010_000, 32'h01020304);
    apply();
    load_byte(8'h77);
    load_byte(8'h88);
    // load strobe rises while reset is held: must be ignored
    @(negedge clk); rst = 1'b1; byte_in = 8'hFF;
    repeat (2) @(negedge clk);
    load_stb = 1'b1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    load_stb = 1'b0;
    repeat (14) @(negedge clk);
    chk("R4 tune cleared", tune, 0);
    chk("R4 phase cleared", phase, 0);
    apply();
    chk("R6 staging kept, R7 blocked load", tune, 32'h88020304);
    chk("R6 phase restored", phase, 5'h0E);
    // pointer back to S0 after reset
    load_frame(8'b00100_000, 32'h55667788);
    master_reset(6);
    load_frame(8'b00101_000, 32'hA1B2C3D4);
    apply();
    chk("R4 pointer at S0 after reset", tune, 32'hA1B2C3D4);
  endtask

  task automatic t_held_strobe();
    @(negedge clk); byte_in = 8'b01000_000; load_stb = 1'b1;
    repeat (40) @(negedge clk);
    load_stb = 1'b0;
    repeat (6) @(negedge clk);
    load_byte(8'hE1); load_byte(8'hE2); load_byte(8'hE3); load_byte(8'hE4);
    apply();
    chk("R9 held strobe acts once", tune, 32'hE1E2E3E4);
    chk("R9 held strobe phase", phase, 5'h08);
  endtask

  initial begin
    repeat (8) @(negedge clk);
    rst = 1'b0;
    repeat (16) @(negedge clk);
    chk("R7 ready after power-on reset", rdy, 1);
    t_reset_timing();
    t_frame();
    t_power();
    t_saturate();
    t_short_reset();
    t_retain_and_block();
    t_held_strobe();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule